// File: doc/BRIEF.md
# Atomic Dispatch Group Former with Dependency Replay

This block sits between a decoded instruction queue and the issue stage of an in-order core. It holds incoming decoded instructions in an internal ring queue and, each cycle the downstream stage is ready, packs the oldest of them into one dispatch group. A group has four ordinary slots and one extra slot reserved for a branch. The whole group either commits or is thrown away; nothing in between is possible.

A store cannot forward its data until it has committed. A load that reads a word written by an older store in the same group therefore cannot commit. In that case the former marks the group as rejected and removes nothing from the queue. It then enters a recovery step: the next group carries only the first instruction of the rejected group, and that group always commits. After this, normal packing resumes. Every rejection is followed by at least one instruction of progress, so a store/load pair that keeps landing in the same group is split after a few rounds.

The register files an instruction reads or writes play no part in the dependency check. Only the store/load flags and the memory word address are compared.

Top module: `gf_dispatch_former`

## Requirements
- R1: A group holds at most four non-branch instructions. They are placed in stream order, oldest first, starting at slot 0 with no gaps.
- R2: The branch slot is used only when the instruction right after the packed non-branch instructions is a branch. That branch ends the group. A branch at the head of the queue forms a group with a branch and no ordinary slots.
- R3: A group is rejected when a load in ordinary slot j and a store in ordinary slot i, with i < j, have equal address bits [ADDR_W-1:2]. The byte offset bits [1:0] are not compared. A load older than the store never causes a reject, and neither does a store and load to different words.
- R4: A rejected group shows grp_reject high, grp_commit low and a count of zero. No instruction leaves the queue, so the next group starts with the same first instruction.
- R5: The group issued after a reject holds exactly one instruction, the first one of the rejected group. It shows grp_recover high and commits. The groups after it are packed normally.
- R6: A committed group raises grp_commit for exactly that one cycle. grp_commit_cnt then equals the number of instructions in the group, branch included, and those instructions leave the queue. grp_commit and grp_reject are low in any cycle without a group.
- R7: A store and a dependent load that are packed together again after a reject lead to further rejects. Each reject still advances the stream by one instruction, until the pair falls into separate groups and both commit.
- R8: A group is issued only when dn_ready is high at a clock edge and the queue is not empty. The group appears on the outputs for one cycle after that edge. At any other time grp_valid stays low.
- R9: Instructions are accepted in order while in_ready is high. in_ready is low exactly when the queue holds DEPTH entries.
- R10: After reset the queue is empty, in_ready is high, and grp_valid, grp_commit and grp_reject are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An instruction is offered |
| in_ready | output | 1 | Queue has room |
| in_tag | input | TAG_W | Instruction identifier |
| in_addr | input | ADDR_W | Byte address of a memory access |
| in_store | input | 1 | Instruction is a store |
| in_load | input | 1 | Instruction is a load |
| in_branch | input | 1 | Instruction is a branch |
| dn_ready | input | 1 | Downstream accepts a group at this edge |
| grp_valid | output | 1 | A group is presented this cycle |
| grp_slot_valid | output | NREG | Ordinary slot occupancy, bit 0 = oldest |
| grp_slot_tag | output | NREG*TAG_W | Slot tags, slot k at bits [k*TAG_W +: TAG_W] |
| grp_br_valid | output | 1 | Branch slot occupied |
| grp_br_tag | output | TAG_W | Branch slot tag |
| grp_commit | output | 1 | Group commits |
| grp_reject | output | 1 | Group rejected, will be replayed |
| grp_recover | output | 1 | Group is the single-instruction recovery group |
| grp_commit_cnt | output | CW | Instructions committed by this group |

## Verification
The bench goes after a store and load to the same word that sit at various distances inside a group. If the design compared byte addresses instead of words, the pair would slip through. If it rewound the queue wrongly, the recovery group would carry the wrong tag, or instructions would be lost or repeated. It also sends a load that is older than a store to the same word, which a design checking the wrong order would reject. Branch runs and a branch at the head of the queue show a design that fills the branch slot out of order, or keeps packing past a branch. A stalled downstream shows a design that issues groups without dn_ready.

// File: rtl/gf_pkg.sv
package gf_pkg;
    parameter int TAG_W  = 8;
    parameter int ADDR_W = 16;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] addr;
        logic              is_st;
        logic              is_ld;
        logic              is_br;
    } instr_t;
endpackage

// File: rtl/gf_queue.sv
module gf_queue #(
    parameter int DEPTH = 16,
    parameter int WIN   = 5,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push_i,
    input  gf_pkg::instr_t       item_i,
    input  logic [CNT_W-1:0]     pop_n_i,
    output gf_pkg::instr_t       win_o [WIN],
    output logic [CNT_W-1:0]     count_o
);
    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
    } qst_t;

    qst_t           st_d, st_q;
    gf_pkg::instr_t mem_q [DEPTH];

    always_comb begin
        st_d     = st_q;
        st_d.rd  = st_q.rd + PTR_W'(pop_n_i);
        st_d.wr  = st_q.wr + PTR_W'(push_i);
        st_d.cnt = st_q.cnt + CNT_W'(push_i) - pop_n_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_i) mem_q[st_q.wr] <= item_i;
    end

    generate
        for (genvar k = 0; k < WIN; k++) begin : g_win
            assign win_o[k] = mem_q[st_q.rd + PTR_W'(k)];
        end
    endgenerate

    assign count_o = st_q.cnt;

    AST_QUEUE_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH)); // R9
    AST_POP_WITHIN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        pop_n_i <= st_q.cnt); // R6
endmodule

// File: rtl/gf_packer.sv
module gf_packer #(
    parameter int NREG  = 4,
    parameter int CNT_W = 5,
    localparam int WIN  = NREG + 1
) (
    input  gf_pkg::instr_t           win_i [WIN],
    input  logic [CNT_W-1:0]         avail_i,
    input  logic                     single_i,
    output logic [NREG-1:0]          reg_v_o,
    output logic                     br_v_o,
    output logic [gf_pkg::TAG_W-1:0] br_tag_o,
    output logic [CNT_W-1:0]         take_o,
    output logic                     conflict_o
);
    localparam int WBITS = gf_pkg::ADDR_W - 2;

    int   nreg;
    int   take;
    logic stop;

    always_comb begin
        nreg     = 0;
        take     = 0;
        stop     = 1'b0;
        br_v_o   = 1'b0;
        br_tag_o = '0;
        for (int k = 0; k < WIN; k++) begin
            if (!stop) begin
                if (CNT_W'(k) >= avail_i || (single_i && k >= 1)) begin
                    stop = 1'b1;
                end else if (win_i[k].is_br) begin
                    br_v_o   = 1'b1;
                    br_tag_o = win_i[k].tag;
                    take     = k + 1;
                    stop     = 1'b1;
                end else if (nreg < NREG) begin
                    nreg = nreg + 1;
                    take = k + 1;
                end else begin
                    stop = 1'b1;
                end
            end
        end
        for (int i = 0; i < NREG; i++) reg_v_o[i] = (i < nreg);
        take_o = CNT_W'(take);
    end

    always_comb begin
        conflict_o = 1'b0;
        for (int i = 0; i < NREG; i++) begin
            for (int j = i + 1; j < NREG; j++) begin
                if (reg_v_o[j] && win_i[i].is_st && win_i[j].is_ld &&
                    win_i[i].addr[gf_pkg::ADDR_W-1 -: WBITS] ==
                    win_i[j].addr[gf_pkg::ADDR_W-1 -: WBITS])
                    conflict_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/gf_dispatch_former.sv
module gf_dispatch_former #(
    parameter int NREG  = 4,
    parameter int DEPTH = 16,
    localparam int TAG_W = gf_pkg::TAG_W,
    localparam int ADDR_W = gf_pkg::ADDR_W,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int CW    = $clog2(NREG + 2)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [TAG_W-1:0]        in_tag,
    input  logic [ADDR_W-1:0]       in_addr,
    input  logic                    in_store,
    input  logic                    in_load,
    input  logic                    in_branch,
    input  logic                    dn_ready,
    output logic                    grp_valid,
    output logic [NREG-1:0]         grp_slot_valid,
    output logic [NREG*TAG_W-1:0]   grp_slot_tag,
    output logic                    grp_br_valid,
    output logic [TAG_W-1:0]        grp_br_tag,
    output logic                    grp_commit,
    output logic                    grp_reject,
    output logic                    grp_recover,
    output logic [CW-1:0]           grp_commit_cnt
);
    localparam int WIN = NREG + 1;

    typedef struct packed {
        logic                       valid;
        logic [NREG-1:0]            slot_v;
        logic [NREG-1:0][TAG_W-1:0] tags;
        logic                       br_v;
        logic [TAG_W-1:0]           br_tag;
        logic                       commit;
        logic                       reject;
        logic                       recover;
        logic [CW-1:0]              cnt;
        logic                       single;
    } fst_t;

    fst_t             st_d, st_q;
    gf_pkg::instr_t   push_item;
    gf_pkg::instr_t   win [WIN];
    logic [CNT_W-1:0] count, pop_n, take;
    logic [NREG-1:0]  reg_v;
    logic             br_v, conflict, push;
    logic [TAG_W-1:0] br_tag;

    assign in_ready  = (count != CNT_W'(DEPTH));
    assign push      = in_valid && in_ready;
    assign push_item = '{tag: in_tag, addr: in_addr, is_st: in_store,
                         is_ld: in_load, is_br: in_branch};

    gf_queue #(.DEPTH(DEPTH), .WIN(WIN)) i_queue (
        .clk(clk), .rst_n(rst_n), .push_i(push), .item_i(push_item),
        .pop_n_i(pop_n), .win_o(win), .count_o(count)
    );

    gf_packer #(.NREG(NREG), .CNT_W(CNT_W)) i_packer (
        .win_i(win), .avail_i(count), .single_i(st_q.single),
        .reg_v_o(reg_v), .br_v_o(br_v), .br_tag_o(br_tag),
        .take_o(take), .conflict_o(conflict)
    );

    always_comb begin
        st_d         = st_q;
        st_d.valid   = 1'b0;
        st_d.slot_v  = '0;
        st_d.tags    = '0;
        st_d.br_v    = 1'b0;
        st_d.br_tag  = '0;
        st_d.commit  = 1'b0;
        st_d.reject  = 1'b0;
        st_d.recover = 1'b0;
        st_d.cnt     = '0;
        pop_n        = '0;
        if (dn_ready && count != '0) begin
            st_d.valid   = 1'b1;
            st_d.slot_v  = reg_v;
            for (int i = 0; i < NREG; i++)
                st_d.tags[i] = reg_v[i] ? win[i].tag : '0;
            st_d.br_v    = br_v;
            st_d.br_tag  = br_tag;
            st_d.recover = st_q.single;
            if (conflict) begin
                st_d.reject = 1'b1;
                st_d.single = 1'b1;
            end else begin
                st_d.commit = 1'b1;
                st_d.cnt    = CW'(take);
                st_d.single = 1'b0;
                pop_n       = take;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign grp_valid      = st_q.valid;
    assign grp_slot_valid = st_q.slot_v;
    assign grp_slot_tag   = st_q.tags;
    assign grp_br_valid   = st_q.br_v;
    assign grp_br_tag     = st_q.br_tag;
    assign grp_commit     = st_q.commit;
    assign grp_reject     = st_q.reject;
    assign grp_recover    = st_q.recover;
    assign grp_commit_cnt = st_q.cnt;

    AST_SLOTS_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid |-> ((grp_slot_valid + 1'b1) & grp_slot_valid) == '0); // R1
    AST_CNT_MATCHES_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
        grp_commit |-> int'(grp_commit_cnt) ==
                       $countones(grp_slot_valid) + int'(grp_br_valid)); // R6
    AST_REJECT_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        grp_reject |-> $countones(grp_slot_valid) >= 2 && grp_commit_cnt == '0); // R3
    AST_RECOVER_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        grp_recover |-> grp_commit &&
                        $countones(grp_slot_valid) + int'(grp_br_valid) == 1); // R5
    AST_REJECT_THEN_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_reject ##1 grp_valid) |-> grp_recover); // R5
    AST_NO_VERDICT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_valid |-> !grp_commit && !grp_reject); // R8
    AST_ISSUE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !dn_ready |=> !grp_valid); // R8
endmodule

// File: tb/test_gf_dispatch_former.sv
`timescale 1ns/1ps
module test_gf_dispatch_former;
    typedef struct {
        logic [7:0]  tag;
        logic [15:0] addr;
        logic        st, ld, br;
    } bi_t;

    typedef struct packed {
        logic [3:0]      sv;
        logic [3:0][7:0] tags;
        logic            brv;
        logic [7:0]      brtag;
        logic            commit;
        logic            reject;
        logic            recover;
        logic [2:0]      cnt;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_store = 1'b0, in_load = 1'b0, in_branch = 1'b0;
    logic dn_ready = 1'b0;
    logic [7:0] in_tag = '0;
    logic [15:0] in_addr = '0;
    logic in_ready, grp_valid, grp_br_valid, grp_commit, grp_reject, grp_recover;
    logic [3:0] grp_slot_valid;
    logic [31:0] grp_slot_tag;
    logic [7:0] grp_br_tag;
    logic [2:0] grp_commit_cnt;

    int errors = 0, checks = 0;
    bi_t   scn[$];
    exp_t  exp_q[$];
    string lab_q[$];

    always #4 clk = ~clk;

    gf_dispatch_former i_gf_dispatch_former (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_tag(in_tag), .in_addr(in_addr), .in_store(in_store), .in_load(in_load),
        .in_branch(in_branch), .dn_ready(dn_ready), .grp_valid(grp_valid),
        .grp_slot_valid(grp_slot_valid), .grp_slot_tag(grp_slot_tag),
        .grp_br_valid(grp_br_valid), .grp_br_tag(grp_br_tag),
        .grp_commit(grp_commit), .grp_reject(grp_reject),
        .grp_recover(grp_recover), .grp_commit_cnt(grp_commit_cnt)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops an expected group for every group the design shows.
    always @(negedge clk) begin
        if (rst_n) begin
            if (grp_valid) begin
                exp_t act;
                act = '{sv: grp_slot_valid, tags: grp_slot_tag, brv: grp_br_valid,
                        brtag: grp_br_tag, commit: grp_commit, reject: grp_reject,
                        recover: grp_recover, cnt: grp_commit_cnt};
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8", "unexpected group", 64'(act), 64'(0));
                end else begin
                    exp_t e;
                    string l;
                    e = exp_q.pop_front();
                    l = lab_q.pop_front();
                    check(act == e, l, "group", 64'(act), 64'(e));
                end
            end else if (grp_commit || grp_reject) begin
                check(1'b0, "R6", "verdict without group",
                      64'({grp_commit, grp_reject}), 64'(0));
            end
        end
    end

    task automatic push(input logic [7:0] tag, input logic st, input logic ld,
                        input logic br, input logic [15:0] addr);
        @(negedge clk);
        in_valid = 1'b1; in_tag = tag; in_store = st; in_load = ld;
        in_branch = br; in_addr = addr;
        scn.push_back('{tag: tag, addr: addr, st: st, ld: ld, br: br});
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    // Builds the expected group sequence from the requirements.
    task automatic model();
        int h = 0;
        bit single = 0;
        while (h < scn.size()) begin
            exp_t e;
            int nreg = 0, take = 0;
            bit stop = 0, conf = 0;
            e = '0;
            for (int k = 0; k < 5; k++) begin
                if (!stop) begin
                    if (h + k >= scn.size() || (single && k >= 1)) stop = 1;
                    else if (scn[h+k].br) begin
                        e.brv = 1; e.brtag = scn[h+k].tag; take = k + 1; stop = 1;
                    end else if (nreg < 4) begin
                        e.sv[nreg] = 1; e.tags[nreg] = scn[h+k].tag;
                        nreg++; take = k + 1;
                    end else stop = 1;
                end
            end
            for (int i = 0; i < nreg; i++)
                for (int j = i + 1; j < nreg; j++)
                    if (scn[h+i].st && scn[h+j].ld &&
                        scn[h+i].addr[15:2] == scn[h+j].addr[15:2]) conf = 1;
            e.recover = single;
            if (conf) begin
                e.reject = 1; single = 1;
                lab_q.push_back("R3 R4 R7");
            end else begin
                e.commit = 1; e.cnt = 3'(take); h += take;
                lab_q.push_back(single ? "R5" : (e.brv ? "R2 R6" : "R1 R6"));
                single = 0;
            end
            exp_q.push_back(e);
        end
    endtask

    task automatic run_scn(input bit toggle);
        int guard = 0;
        @(negedge clk);
        check(grp_valid == 1'b0, "R8", "no group while dn_ready low", 64'(grp_valid), 0);
        model();
        dn_ready = 1'b1;
        while (exp_q.size() != 0 && guard < 300) begin
            @(negedge clk);
            #1;
            if (toggle) dn_ready = ~dn_ready;
            guard++;
        end
        dn_ready = 1'b0;
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R6", "all expected groups seen", 64'(exp_q.size()), 0);
        check(in_ready == 1'b1, "R6", "queue drained after commits", 64'(in_ready), 1);
        exp_q.delete(); lab_q.delete(); scn.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R8", "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(grp_valid == 0 && grp_commit == 0 && grp_reject == 0, "R10",
              "outputs in reset", 64'({grp_valid, grp_commit, grp_reject}), 0);
        check(in_ready == 1, "R10", "in_ready in reset", 64'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(grp_valid == 0, "R10", "idle after reset", 64'(grp_valid), 0);

        // Scenario A: sixteen plain instructions fill the queue (R1, R9)
        for (int i = 0; i < 16; i++) push(8'(8'h10 + i), 0, 0, 0, 16'(i * 4));
        @(negedge clk);
        check(in_ready == 0, "R9", "in_ready low when full", 64'(in_ready), 0);
        run_scn(0);

        // Scenario B: branch placement (R2), with a stalling downstream (R8)
        push(8'h20, 0, 0, 0, 0);  push(8'h21, 0, 0, 1, 0);
        for (int i = 0; i < 4; i++) push(8'(8'h22 + i), 0, 0, 0, 0);
        push(8'h26, 0, 0, 1, 0);  push(8'h27, 0, 0, 1, 0);
        for (int i = 0; i < 5; i++) push(8'(8'h28 + i), 0, 0, 0, 0);
        run_scn(1);

        // Scenario C: store/load dependencies, reject and recovery (R3 R4 R5 R7)
        push(8'h30, 1, 0, 0, 16'h0100);
        push(8'h31, 0, 0, 0, 16'h0000);
        push(8'h32, 1, 0, 0, 16'h0200);
        push(8'h33, 0, 1, 0, 16'h0201);
        push(8'h34, 0, 0, 0, 16'h0000);
        push(8'h35, 0, 1, 0, 16'h0100);
        push(8'h36, 0, 1, 0, 16'h0300);
        push(8'h37, 1, 0, 0, 16'h0300);
        push(8'h38, 1, 0, 0, 16'h0400);
        push(8'h39, 0, 1, 0, 16'h0404);
        push(8'h3a, 0, 0, 1, 16'h0000);
        run_scn(0);

        // Scenario D: branch at queue head, then adjacent store/load (R2 R3 R5)
        push(8'h40, 0, 0, 1, 0);
        push(8'h41, 1, 0, 0, 16'h0800);
        push(8'h42, 0, 1, 0, 16'h0803);
        push(8'h43, 0, 0, 1, 0);
        run_scn(0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule